// File: doc/BRIEF.md
# Multiplexed System Bus Master (Processor Side)

This block sits at the processor end of a shared system bus. One 32-bit lane carries both addresses and data, and a 5-bit command lane runs beside it. The core hands the block read and write requests on a small local port. The block turns each request into an address cycle followed by data cycles. It holds the address cycle until the external agent accepts it, and it splits 5 to 7 byte writes into two transactions.

After a read has been issued, the block releases the bus. The agent then drives both lanes, may run its own traffic, and returns the read data tagged as response data. When the final response word arrives, the block takes mastership back. It waits one more cycle before it turns its drivers on again.

The pads are bidirectional, but this block does not drive them directly. It provides separate outgoing values, incoming values and output enables for them, and the pad ring combines these.

Top module: `sysbus_master`

## Requirements
- R1: During and right after reset, `master_n` is 0, `out_valid_n` is 1, both output enables are 1, `req_ready` is 1 and `rd_valid` is 0.
- R2: An address cycle has `out_valid_n` low and `sys_ad_o` equal to the address.
  - `sys_cmd_o[4]` is 0.
  - `sys_cmd_o[3]` is 1 for a write and 0 for a read.
  - `sys_cmd_o[2:0]` is the size code: n-1 for 1 to 4 bytes, 4 for 8 bytes, 5 for 16 bytes and 6 for 32 bytes. A read of 5 to 7 bytes uses code 4.
- R3: The address cycle repeats unchanged on every clock until `agent_ok_n` is sampled low. That clock edge is the issue.
- R4: Write data cycles follow the issue with no gap, and the block stays master throughout. Each data cycle has:
  - `out_valid_n` low;
  - `sys_cmd_o[4]` = 1 and `sys_cmd_o[2:0]` = 0;
  - `sys_cmd_o[3]` = 1 on the final data cycle only;
  - `sys_ad_o` equal to `wr_data`, with `wr_take` high and `wr_word` giving the word offset from the request address.
  A write of 1 to 4 bytes takes one data cycle. Writes of 8, 16 and 32 bytes take 2, 4 and 8 data cycles.
- R5: A write of 5, 6 or 7 bytes runs as two back-to-back transactions. The first is 4 bytes at the request address (code 3, word 0). The second is the remaining bytes at the address plus 4 (code n-5, word 1).
- R6: On the cycle after a read issue, the block releases the bus and refuses further requests until the response ends:
  - `master_n` goes to 1;
  - both enables go to 0;
  - `out_valid_n` goes to 1;
  - `req_ready` goes to 0.
- R7: A response word is an agent cycle, while the block is slave, with `agent_valid_n` low, `sys_cmd_i[4]` = 1 and `sys_cmd_i[2]` = 1. One cycle after each such cycle, `rd_valid` is 1, `rd_data` holds the word and `rd_last` equals `sys_cmd_i[3]`. Agent cycles with `sys_cmd_i[2]` = 0 produce no `rd_valid`.
- R8: After the response word with `sys_cmd_i[3]` = 1:
  - on the next cycle, `master_n` is 0 while the enables are still 0;
  - one cycle later, the enables are 1 and `req_ready` is 1.
- R9: A request accepted on the final data cycle of a write starts its address cycle on the very next clock, with no idle cycle.
- R10: Response-like agent cycles while the block is master leave `rd_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Local request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request byte address |
| req_bytes | input | 6 | Request length in bytes (1 to 32) |
| wr_data | input | 32 | Write word for the current data cycle |
| wr_take | output | 1 | Write word consumed this cycle |
| wr_word | output | 3 | Word offset of the write word requested |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| rd_last | output | 1 | Read word is the final one |
| sys_ad_o | output | 32 | Outgoing address/data value |
| sys_ad_i | input | 32 | Incoming address/data value |
| sys_ad_oe | output | 1 | Address/data driver enable |
| sys_cmd_o | output | 5 | Outgoing command/identifier |
| sys_cmd_i | input | 5 | Incoming command/identifier |
| sys_cmd_oe | output | 1 | Command driver enable |
| out_valid_n | output | 1 | Block drives a valid cycle (active low) |
| agent_ok_n | input | 1 | Agent accepts the address cycle (active low) |
| agent_valid_n | input | 1 | Agent drives a valid cycle (active low) |
| master_n | output | 1 | Block is bus master (active low) |

## Verification
The state register decides who drives the bus, so a wrong state shows up at the ports in the very next cycle. Typical symptoms are an enable high while `master_n` is 1, a missing address repeat, or a data cycle with no issue before it. A wrong beat count or a lost split flag appears within one transaction: the last-data identifier lands on the wrong cycle, or the second address is not the original plus 4. If the release and regain sequence gets out of step, the bench sees it in the same cycle as a wrong enable or `req_ready`, or a cycle later as a missing or spurious `rd_valid`.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
  localparam int BUS_W  = 32;
  localparam int CMD_W  = 5;
  localparam int SIZE_W = 6;
  localparam int BEAT_W = 4;
  localparam int WORD_W = 3;
  localparam int CODE_W = CMD_W - 2;

  localparam logic CYC_ADDR = 1'b0;
  localparam logic CYC_DATA = 1'b1;
  localparam int   ID_LAST_BIT = 3;
  localparam int   ID_RESP_BIT = 2;
  localparam int   KIND_BIT    = CMD_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_SLAVE, ST_REGAIN
  } bus_st_e;

  function automatic logic [CODE_W-1:0] size_code(input logic [SIZE_W-1:0] n);
    if (n == '0)             return '0;
    else if (n <= SIZE_W'(4))  return CODE_W'(n - SIZE_W'(1));
    else if (n <= SIZE_W'(8))  return CODE_W'(4);
    else if (n <= SIZE_W'(16)) return CODE_W'(5);
    else                       return CODE_W'(6);
  endfunction

  function automatic logic [BEAT_W-1:0] beat_count(input logic [SIZE_W-1:0] n);
    logic [SIZE_W:0] wide;
    wide = {1'b0, n} + (SIZE_W+1)'(3);
    if (n <= SIZE_W'(4)) return BEAT_W'(1);
    else                 return BEAT_W'(wide >> 2);
  endfunction

  function automatic logic needs_split(input logic wr, input logic [SIZE_W-1:0] n);
    return wr && (n >= SIZE_W'(5)) && (n <= SIZE_W'(7));
  endfunction
endpackage

// File: rtl/sysbus_req_plan.sv
module sysbus_req_plan
  import sysbus_pkg::*;
(
  input  logic              req_write,
  input  logic [SIZE_W-1:0] req_bytes,
  output logic              split,
  output logic [SIZE_W-1:0] first_bytes,
  output logic [SIZE_W-1:0] rest_bytes
);
  always_comb begin
    split       = needs_split(req_write, req_bytes);
    first_bytes = split ? SIZE_W'(4) : req_bytes;
    rest_bytes  = req_bytes - SIZE_W'(4);
  end
endmodule

// File: rtl/sysbus_resp_rx.sv
module sysbus_resp_rx
  import sysbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_active,
  input  logic             agent_valid_n,
  input  logic [CMD_W-1:0] sys_cmd_i,
  input  logic [BUS_W-1:0] sys_ad_i,
  output logic             resp_hit,
  output logic             resp_done,
  output logic             rd_valid,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_last
);
  logic unused_id_bits;
  assign unused_id_bits = ^sys_cmd_i[1:0];

  assign resp_hit  = slave_active && !agent_valid_n &&
                     (sys_cmd_i[KIND_BIT] == CYC_DATA) && sys_cmd_i[ID_RESP_BIT];
  assign resp_done = resp_hit && sys_cmd_i[ID_LAST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= resp_hit;
      rd_last  <= resp_done;
      if (resp_hit) rd_data <= sys_ad_i;
    end
  end
endmodule

// File: rtl/sysbus_ctrl.sv
module sysbus_ctrl
  import sysbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_addr,
  input  logic              plan_split,
  input  logic [SIZE_W-1:0] plan_first,
  input  logic [SIZE_W-1:0] plan_rest,
  input  logic              agent_ok_n,
  input  logic              resp_done,
  output bus_st_e           st,
  output logic [BUS_W-1:0]  addr_q,
  output logic              cur_write,
  output logic [CODE_W-1:0] cur_code,
  output logic [WORD_W-1:0] word_q,
  output logic              last_beat,
  output logic              req_ready,
  output logic              issue_evt
);
  logic [SIZE_W-1:0] cur_bytes;
  logic [SIZE_W-1:0] rest_q;
  logic              split_q;
  logic [BEAT_W-1:0] beat_q;
  logic              accept;

  assign cur_code  = size_code(cur_bytes);
  assign last_beat = (st == ST_DATA) && (beat_q == beat_count(cur_bytes) - BEAT_W'(1));
  assign req_ready = (st == ST_IDLE) || (last_beat && !split_q);
  assign accept    = req_valid && req_ready;
  assign issue_evt = (st == ST_ADDR) && !agent_ok_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      cur_write <= 1'b0;
      cur_bytes <= '0;
      rest_q    <= '0;
      split_q   <= 1'b0;
      beat_q    <= '0;
      word_q    <= '0;
    end else if (accept) begin
      st        <= ST_ADDR;
      addr_q    <= req_addr;
      cur_write <= req_write;
      cur_bytes <= plan_first;
      rest_q    <= plan_rest;
      split_q   <= plan_split;
      beat_q    <= '0;
      word_q    <= '0;
    end else begin
      case (st)
        ST_ADDR: if (issue_evt) begin
          st     <= cur_write ? ST_DATA : ST_SLAVE;
          beat_q <= '0;
        end
        ST_DATA: begin
          word_q <= word_q + WORD_W'(1);
          beat_q <= beat_q + BEAT_W'(1);
          if (last_beat) begin
            if (split_q) begin
              st        <= ST_ADDR;
              addr_q    <= addr_q + BUS_W'(4);
              cur_bytes <= rest_q;
              split_q   <= 1'b0;
              beat_q    <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_SLAVE:  if (resp_done) st <= ST_REGAIN;
        ST_REGAIN: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sysbus_master.sv
module sysbus_master
  import sysbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_addr,
  input  logic [SIZE_W-1:0] req_bytes,
  input  logic [BUS_W-1:0]  wr_data,
  output logic              wr_take,
  output logic [WORD_W-1:0] wr_word,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_last,
  output logic [BUS_W-1:0]  sys_ad_o,
  input  logic [BUS_W-1:0]  sys_ad_i,
  output logic              sys_ad_oe,
  output logic [CMD_W-1:0]  sys_cmd_o,
  input  logic [CMD_W-1:0]  sys_cmd_i,
  output logic              sys_cmd_oe,
  output logic              out_valid_n,
  input  logic              agent_ok_n,
  input  logic              agent_valid_n,
  output logic              master_n
);
  logic              plan_split;
  logic [SIZE_W-1:0] plan_first;
  logic [SIZE_W-1:0] plan_rest;
  bus_st_e           st;
  logic [BUS_W-1:0]  addr_q;
  logic              cur_write;
  logic [CODE_W-1:0] cur_code;
  logic              last_beat;
  logic              issue_evt;
  logic              resp_hit;
  logic              resp_done;
  logic              drive_en;

  sysbus_req_plan u_plan (
    .req_write   (req_write),
    .req_bytes   (req_bytes),
    .split       (plan_split),
    .first_bytes (plan_first),
    .rest_bytes  (plan_rest)
  );

  sysbus_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .plan_split (plan_split),
    .plan_first (plan_first),
    .plan_rest  (plan_rest),
    .agent_ok_n (agent_ok_n),
    .resp_done  (resp_done),
    .st         (st),
    .addr_q     (addr_q),
    .cur_write  (cur_write),
    .cur_code   (cur_code),
    .word_q     (wr_word),
    .last_beat  (last_beat),
    .req_ready  (req_ready),
    .issue_evt  (issue_evt)
  );

  sysbus_resp_rx u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .slave_active  (st == ST_SLAVE),
    .agent_valid_n (agent_valid_n),
    .sys_cmd_i     (sys_cmd_i),
    .sys_ad_i      (sys_ad_i),
    .resp_hit      (resp_hit),
    .resp_done     (resp_done),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .rd_last       (rd_last)
  );

  assign drive_en    = (st == ST_IDLE) || (st == ST_ADDR) || (st == ST_DATA);
  assign sys_ad_oe   = drive_en;
  assign sys_cmd_oe  = drive_en;
  assign master_n    = (st == ST_SLAVE);
  assign out_valid_n = !((st == ST_ADDR) || (st == ST_DATA));
  assign wr_take     = (st == ST_DATA);

  always_comb begin
    sys_ad_o  = '0;
    sys_cmd_o = '0;
    if (st == ST_ADDR) begin
      sys_ad_o  = addr_q;
      sys_cmd_o = {CYC_ADDR, cur_write, cur_code};
    end else if (st == ST_DATA) begin
      sys_ad_o  = wr_data;
      sys_cmd_o = {CYC_DATA, last_beat, 3'b000};
    end
  end
endmodule

// File: rtl/sysbus_master_chk.sv
module sysbus_master_chk
  import sysbus_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             issue_evt,
  input logic             out_valid_n,
  input logic             agent_ok_n,
  input logic             master_n,
  input logic             sys_ad_oe,
  input logic             sys_cmd_oe,
  input logic [CMD_W-1:0] sys_cmd_o,
  input logic [BUS_W-1:0] sys_ad_o,
  input logic             req_ready,
  input logic             rd_valid
);
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid_n && !sys_cmd_o[KIND_BIT] && agent_ok_n) |=>
    (!out_valid_n && !sys_cmd_o[KIND_BIT] && $stable(sys_ad_o) && $stable(sys_cmd_o)));

  a_r4_write_data_next: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_evt && sys_cmd_o[3]) |=> (!out_valid_n && sys_cmd_o[KIND_BIT] && !master_n));

  a_r6_release_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_evt && !sys_cmd_o[3]) |=> (master_n && !sys_ad_oe && !sys_cmd_oe));

  a_r6_quiet_when_slave: assert property (@(posedge clk) disable iff (!rst_n)
    master_n |-> (!sys_ad_oe && !sys_cmd_oe && out_valid_n && !req_ready));

  a_r8_regain_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master_n) |-> (!sys_ad_oe && !sys_cmd_oe));

  a_r10_resp_only_from_slave: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(master_n));
endmodule

bind sysbus_master sysbus_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_evt   (issue_evt),
  .out_valid_n (out_valid_n),
  .agent_ok_n  (agent_ok_n),
  .master_n    (master_n),
  .sys_ad_oe   (sys_ad_oe),
  .sys_cmd_oe  (sys_cmd_oe),
  .sys_cmd_o   (sys_cmd_o),
  .sys_ad_o    (sys_ad_o),
  .req_ready   (req_ready),
  .rd_valid    (rd_valid)
);

// File: tb/sysbus_master_bench.sv
`timescale 1ns/1ps
module sysbus_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [5:0]  req_bytes = '0;
  logic [31:0] wr_data;
  logic        wr_take;
  logic [2:0]  wr_word;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rd_last;
  logic [31:0] sys_ad_o;
  logic [31:0] sys_ad_i = '0;
  logic        sys_ad_oe;
  logic [4:0]  sys_cmd_o;
  logic [4:0]  sys_cmd_i = '0;
  logic        sys_cmd_oe;
  logic        out_valid_n;
  logic        agent_ok_n = 1'b1;
  logic        agent_valid_n = 1'b1;
  logic        master_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign wr_data = {8'hC3, 21'd0, wr_word};

  sysbus_master u_sysbus_master (.*);

  // {write, bytes, delay, responses, address}
  localparam logic [44:0] VEC [10] = '{
    {1'b1, 6'd4,  2'd0, 4'd0, 32'h0000_1000},
    {1'b1, 6'd1,  2'd2, 4'd0, 32'h0000_1005},
    {1'b1, 6'd8,  2'd1, 4'd0, 32'h0000_2000},
    {1'b1, 6'd32, 2'd0, 4'd0, 32'h0000_3000},
    {1'b1, 6'd6,  2'd1, 4'd0, 32'h0000_4000},
    {1'b0, 6'd4,  2'd1, 4'd1, 32'h0000_5000},
    {1'b0, 6'd16, 2'd0, 4'd4, 32'h0000_6000},
    {1'b0, 6'd6,  2'd2, 4'd2, 32'h0000_7000},
    {1'b1, 6'd7,  2'd3, 4'd0, 32'h0000_8000},
    {1'b1, 6'd3,  2'd0, 4'd0, 32'h0000_8800}
  };

  function automatic logic [2:0] exp_code(input int n);
    case (n)
      1: return 3'd0;
      2: return 3'd1;
      3: return 3'd2;
      4: return 3'd3;
      5, 6, 7, 8: return 3'd4;
      16: return 3'd5;
      32: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic int exp_beats(input int n);
    if (n <= 4) return 1;
    return n / 4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_req(input logic w, input logic [31:0] a, input logic [5:0] n);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_bytes = n;
  endtask

  task automatic check_addr(input logic [31:0] a, input logic w, input logic [2:0] code, input int d);
    for (int i = 0; i <= d; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 address valid strobe", {31'd0, out_valid_n}, 32'd0);
      chk("R2 address command", {27'd0, sys_cmd_o}, {27'd0, 1'b0, w, code});
      chk("R2 address value", sys_ad_o, a);
      if (i > 0) chk("R3 address repeated", {31'd0, master_n}, 32'd0);
      agent_ok_n = (i == d) ? 1'b0 : 1'b1;
    end
  endtask

  task automatic check_data(input int nb, input int w0);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      agent_ok_n = 1'b1;
      chk("R4 data strobe/take", {30'd0, out_valid_n, wr_take}, 32'd1);
      chk("R4 data identifier", {27'd0, sys_cmd_o}, {27'd0, 1'b1, (b == nb - 1), 3'b000});
      chk("R4 data word", sys_ad_o, {8'hC3, 21'd0, 3'(w0 + b)});
      chk("R4 master held", {31'd0, master_n}, 32'd0);
    end
  endtask

  task automatic check_idle();
    @(negedge clk);
    chk("R4 idle after write", {29'd0, out_valid_n, sys_ad_oe, req_ready}, 32'd7);
  endtask

  task automatic do_write(input logic [31:0] a, input int n, input int d);
    drive_req(1'b1, a, 6'(n));
    if (n >= 5 && n <= 7) begin
      check_addr(a, 1'b1, 3'd3, d);
      check_data(1, 0);
      check_addr(a + 32'd4, 1'b1, 3'(n - 5), 0);  // R5 second part
      check_data(1, 1);
    end else begin
      check_addr(a, 1'b1, exp_code(n), d);
      check_data(exp_beats(n), 0);
    end
    check_idle();
  endtask

  task automatic do_read(input logic [31:0] a, input int n, input int d, input int nr);
    drive_req(1'b0, a, 6'(n));
    check_addr(a, 1'b0, exp_code(n), d);
    @(negedge clk);
    agent_ok_n = 1'b1;
    chk("R6 released", {28'd0, master_n, sys_ad_oe, sys_cmd_oe, out_valid_n}, 32'b1001);
    req_valid = 1'b1; req_write = 1'b0;
    @(negedge clk);
    chk("R6 second read stalled", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b0;
    agent_valid_n = 1'b0; sys_cmd_i = 5'b10000; sys_ad_i = 32'hDEAD_0000;
    for (int k = 0; k < nr; k++) begin
      @(negedge clk);
      if (k == 0) begin
        chk("R7 agent write ignored", {31'd0, rd_valid}, 32'd0);
      end else begin
        chk("R7 response valid", {30'd0, rd_valid, rd_last}, 32'b10);
        chk("R7 response data", rd_data, {a[15:0], 16'(k - 1)});
      end
      sys_cmd_i = {1'b1, (k == nr - 1), 1'b1, 2'b00};
      sys_ad_i  = {a[15:0], 16'(k)};
    end
    @(negedge clk);
    agent_valid_n = 1'b1; sys_cmd_i = '0;
    chk("R7 final response", {30'd0, rd_valid, rd_last}, 32'b11);
    chk("R7 final data", rd_data, {a[15:0], 16'(nr - 1)});
    chk("R8 master back, drivers off", {29'd0, master_n, sys_ad_oe, sys_cmd_oe}, 32'd0);
    @(negedge clk);
    chk("R8 drivers on", {29'd0, sys_ad_oe, sys_cmd_oe, req_ready}, 32'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset master/valid", {30'd0, master_n, out_valid_n}, 32'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {27'd0, master_n, out_valid_n, sys_ad_oe, req_ready, rd_valid}, 32'b01110);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][44])
        do_write(VEC[i][31:0], int'(VEC[i][43:38]), int'(VEC[i][37:36]));
      else
        do_read(VEC[i][31:0], int'(VEC[i][43:38]), int'(VEC[i][37:36]), int'(VEC[i][35:32]));
    end

    // R10: response-shaped cycle while master
    @(negedge clk);
    agent_valid_n = 1'b0; sys_cmd_i = 5'b11100; sys_ad_i = 32'h1234_5678;
    @(negedge clk);
    agent_valid_n = 1'b1; sys_cmd_i = '0;
    chk("R10 no rd_valid while master", {31'd0, rd_valid}, 32'd0);
    @(negedge clk);
    chk("R10 still master", {31'd0, master_n}, 32'd0);

    // R9: back-to-back writes
    drive_req(1'b1, 32'h0000_9000, 6'd4);
    check_addr(32'h0000_9000, 1'b1, 3'd3, 0);
    check_data(1, 0);
    chk("R9 ready on final data cycle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_9100; req_bytes = 6'd2;
    check_addr(32'h0000_9100, 1'b1, 3'd1, 0);  // R9 no idle cycle
    check_data(1, 0);
    check_idle();

    // R5: split 5-byte write, no agent delay
    do_write(32'h0000_A000, 5, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-R actual=hang expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule